// File: doc/BRIEF.md
# Interrupt Redirection to Message-Signalled Interrupt Generator

This block is the service stage of an I/O interrupt controller. It keeps a table of 24 routing entries, each 64 bits wide, and one pending bit for each interrupt input pin. A scanner steps through the pins one per cycle. When it finds a pin whose request is pending and whose entry is unmasked, it turns that entry into a message-signalled interrupt: a 32-bit write address and a 32-bit data word. The message is then offered on a valid/ready port.

Edge-triggered pins consume their pending bit when their message is generated. Level-triggered pins instead set a remote-IRR flag in their entry, and further requests are coalesced until an end-of-interrupt with the matching vector clears that flag. An entry set up for external-interrupt delivery takes its vector from a legacy controller over a request/acknowledge port, not from the entry.

Top module: `irq_msi_redirector`

## Requirements
- R1: After reset every entry reads back as 64'h0000_0000_0001_0000 (only the mask bit 16 set). No message is valid and no legacy request is raised.
- R2: The entry layout is: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], remote IRR [14], trigger [15] (1 = level), mask [16], destination [63:48]. Every written bit reads back unchanged except bit 14. Bit 14 always shows the internal remote-IRR state, and writes to it are ignored.
- R3: A pin whose entry has mask bit 16 set produces no message. A request captured while the pin is masked stays pending and is sent once the entry is unmasked.
- R4: A pin is asserted when its line XOR polarity bit 13 is 1. On an edge-triggered pin, a rising transition of the asserted state sets the pending bit, and generating the message clears it. This gives exactly one message per transition.
- R5: On a level-triggered pin, the pending state follows the asserted state. Generating the message sets remote IRR (read back at bit 14). While remote IRR is set, further requests are coalesced and send no message.
- R6: An end-of-interrupt with vector V clears remote IRR in every level-triggered entry whose vector field is V. A cleared pin whose line is still asserted sends a new message. Entries with another vector keep remote IRR.
- R7: The message address is 32'hFEE0_0000 OR (destination << 12) OR (destination mode << 2).
- R8: The message data holds the vector in [7:0], the delivery mode in [10:8] and the trigger bit in [15]; all other bits are zero.
- R9: For delivery mode 3'b111, the block raises ext_req_o and holds it until ext_ack_i. The vector sampled from ext_vec_i with the acknowledge replaces the entry's vector in the message data.
- R10: Once valid, a message holds its address and data stable until msg_ready_i is seen high.
- R11: At most one pin is serviced at a time. After a message is accepted, the scan resumes at the next pin upward and wraps from pin 23 to pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_line_i | input | 24 | Interrupt input lines, one per pin |
| cfg_we_i | input | 1 | Write strobe for a table entry |
| cfg_idx_i | input | 5 | Entry index for the write |
| cfg_wdata_i | input | 64 | Entry value to write |
| cfg_ridx_i | input | 5 | Entry index for the read-back |
| cfg_rdata_o | output | 64 | Entry value at cfg_ridx_i, with live remote IRR at bit 14 |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | 8 | End-of-interrupt vector |
| ext_req_o | output | 1 | Vector request to the legacy controller |
| ext_ack_i | input | 1 | Legacy controller acknowledge |
| ext_vec_i | input | 8 | Vector from the legacy controller, valid with the acknowledge |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The bound checker checks four things on every cycle: that a valid message holds stable under backpressure, that the legacy request persists until it is acknowledged, that at most one pin is serviced per cycle, and that no masked pin or level pin with remote IRR set is ever serviced. It also checks that a message and a legacy request are never active together. The bench scenarios show what those per-cycle rules cannot: the exact address and data packing, the one-message-per-edge behaviour, coalescing and re-delivery after a matching end-of-interrupt, polarity inversion, the external vector substitution, and the wrap-around scan order after a stall.

// File: rtl/irq_msi_pkg.sv
package irq_msi_pkg;
  localparam int unsigned ENT_W     = 64;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned DEST_W    = 16;
  localparam int unsigned DM_LSB    = 8;
  localparam int unsigned DMODE_BIT = 11;
  localparam int unsigned POL_BIT   = 13;
  localparam int unsigned RIRR_BIT  = 14;
  localparam int unsigned TRIG_BIT  = 15;
  localparam int unsigned MASK_BIT  = 16;
  localparam int unsigned DEST_LSB  = 48;
  localparam logic [2:0]  DM_EXTINT = 3'b111;
  localparam logic [31:0] MSG_BASE  = 32'hFEE0_0000;
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << MASK_BIT;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              dmode;
    logic              trig;
    logic [2:0]        dm;
    logic [VEC_W-1:0]  vec;
  } route_t;

  typedef enum logic [1:0] {ST_SCAN, ST_FETCH, ST_SEND} scan_st_e;

  function automatic logic [31:0] msg_addr(route_t r);
    return MSG_BASE | (32'(r.dest) << 12) | (32'(r.dmode) << 2);
  endfunction

  function automatic logic [31:0] msg_data(route_t r, logic [VEC_W-1:0] v);
    return 32'(v) | (32'(r.dm) << DM_LSB) | (32'(r.trig) << 15);
  endfunction
endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_msi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [ENT_W-1:0]    wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [ENT_W-1:0]    rd_data_o,
  input  logic                eoi_valid_i,
  input  logic [VEC_W-1:0]    eoi_vec_i,
  input  logic [NUM_PINS-1:0] set_rirr_i,
  output logic [NUM_PINS-1:0] rirr_o,
  output logic [ENT_W-1:0]    ent_o [NUM_PINS]
);
  localparam logic [ENT_W-1:0] RIRR_MSK = ENT_W'(1) << RIRR_BIT;

  logic [ENT_W-1:0]    ent_q [NUM_PINS];
  logic [NUM_PINS-1:0] rirr_q;
  logic [NUM_PINS-1:0] eoi_hit;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= ENT_RST;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        ent_q[g] <= wr_data_i & ~RIRR_MSK;
      end
    end

    assign eoi_hit[g] = eoi_valid_i && ent_q[g][TRIG_BIT] &&
                        (ent_q[g][VEC_W-1:0] == eoi_vec_i);

    // a new message on the same cycle wins over the clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rirr_q[g] <= 1'b0;
      else         rirr_q[g] <= set_rirr_i[g] | (rirr_q[g] & ~eoi_hit[g]);
    end

    assign ent_o[g] = ent_q[g] | (ENT_W'(rirr_q[g]) << RIRR_BIT);
  end

  assign rirr_o    = rirr_q;
  assign rd_data_o = (32'(rd_idx_i) < NUM_PINS) ? ent_o[rd_idx_i] : '0;
endmodule

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] line_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] act;
  logic [NUM_PINS-1:0] act_q;
  logic [NUM_PINS-1:0] pend_q;

  assign act = line_i ^ pol_i;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        act_q[g] <= act[g];
        if (level_i[g]) pend_q[g] <= act[g];
        else            pend_q[g] <= (pend_q[g] & ~clr_i[g]) | (act[g] & ~act_q[g]);
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_msi_scan.sv
module irq_msi_scan
  import irq_msi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] elig_i,
  input  route_t              route_i [NUM_PINS],
  output logic                ext_req_o,
  input  logic                ext_ack_i,
  input  logic [VEC_W-1:0]    ext_vec_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [31:0]         msg_addr_o,
  output logic [31:0]         msg_data_o,
  output logic [NUM_PINS-1:0] clr_pend_o,
  output logic [NUM_PINS-1:0] set_rirr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PINS - 1);

  scan_st_e         st_q;
  logic [IDX_W-1:0] ptr_q, ptr_nxt;
  logic [31:0]      addr_q, data_q;
  route_t           cur;
  logic             hit;

  assign cur     = route_i[ptr_q];
  assign hit     = (st_q == ST_SCAN) && elig_i[ptr_q];
  assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_comb begin
    clr_pend_o = '0;
    set_rirr_o = '0;
    if (hit) begin
      if (cur.trig) set_rirr_o[ptr_q] = 1'b1;
      else          clr_pend_o[ptr_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SCAN;
      ptr_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_SCAN: begin
          if (hit) begin
            addr_q <= msg_addr(cur);
            data_q <= msg_data(cur, cur.vec);
            st_q   <= (cur.dm == DM_EXTINT) ? ST_FETCH : ST_SEND;
          end else begin
            ptr_q <= ptr_nxt;
          end
        end
        ST_FETCH: begin
          if (ext_ack_i) begin
            data_q[VEC_W-1:0] <= ext_vec_i;
            st_q              <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (msg_ready_i) begin
            ptr_q <= ptr_nxt;
            st_q  <= ST_SCAN;
          end
        end
        default: st_q <= ST_SCAN;
      endcase
    end
  end

  assign ext_req_o   = (st_q == ST_FETCH);
  assign msg_valid_o = (st_q == ST_SEND);
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = data_q;
endmodule

// File: rtl/irq_msi_redirector.sv
module irq_msi_redirector
  import irq_msi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_line_i,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [ENT_W-1:0]    cfg_wdata_i,
  input  logic [IDX_W-1:0]    cfg_ridx_i,
  output logic [ENT_W-1:0]    cfg_rdata_o,
  input  logic                eoi_valid_i,
  input  logic [VEC_W-1:0]    eoi_vec_i,
  output logic                ext_req_o,
  input  logic                ext_ack_i,
  input  logic [VEC_W-1:0]    ext_vec_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [31:0]         msg_addr_o,
  output logic [31:0]         msg_data_o
);
  logic [ENT_W-1:0]    ent [NUM_PINS];
  route_t              route [NUM_PINS];
  logic [NUM_PINS-1:0] mask_v, trig_v, pol_v, rirr_v, pend_v, elig_v;
  logic [NUM_PINS-1:0] clr_pend, set_rirr;

  irq_redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni,
    .wr_en_i     (cfg_we_i),
    .wr_idx_i    (cfg_idx_i),
    .wr_data_i   (cfg_wdata_i),
    .rd_idx_i    (cfg_ridx_i),
    .rd_data_o   (cfg_rdata_o),
    .eoi_valid_i (eoi_valid_i),
    .eoi_vec_i   (eoi_vec_i),
    .set_rirr_i  (set_rirr),
    .rirr_o      (rirr_v),
    .ent_o       (ent)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
    assign mask_v[g]      = ent[g][MASK_BIT];
    assign trig_v[g]      = ent[g][TRIG_BIT];
    assign pol_v[g]       = ent[g][POL_BIT];
    assign route[g].dest  = ent[g][DEST_LSB +: DEST_W];
    assign route[g].dmode = ent[g][DMODE_BIT];
    assign route[g].trig  = ent[g][TRIG_BIT];
    assign route[g].dm    = ent[g][DM_LSB +: 3];
    assign route[g].vec   = ent[g][VEC_W-1:0];
  end

  irq_pend_capture #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk_i, .rst_ni,
    .line_i  (irq_line_i),
    .pol_i   (pol_v),
    .level_i (trig_v),
    .clr_i   (clr_pend),
    .pend_o  (pend_v)
  );

  // level pins with remote IRR outstanding are coalesced
  assign elig_v = pend_v & ~mask_v & ~(trig_v & rirr_v);

  irq_msi_scan #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_scan (
    .clk_i, .rst_ni,
    .elig_i      (elig_v),
    .route_i     (route),
    .ext_req_o   (ext_req_o),
    .ext_ack_i   (ext_ack_i),
    .ext_vec_i   (ext_vec_i),
    .msg_valid_o (msg_valid_o),
    .msg_ready_i (msg_ready_i),
    .msg_addr_o  (msg_addr_o),
    .msg_data_o  (msg_data_o),
    .clr_pend_o  (clr_pend),
    .set_rirr_o  (set_rirr)
  );
endmodule

// File: rtl/irq_msi_chk.sv
module irq_msi_chk #(
  parameter int unsigned NUM_PINS = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                msg_valid_o,
  input logic                msg_ready_i,
  input logic [31:0]         msg_addr_o,
  input logic [31:0]         msg_data_o,
  input logic                ext_req_o,
  input logic                ext_ack_i,
  input logic [NUM_PINS-1:0] clr_pend_i,
  input logic [NUM_PINS-1:0] set_rirr_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic [NUM_PINS-1:0] rirr_i
);
  // R11
  one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_pend_i | set_rirr_i));

  // R11
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_req_o && msg_valid_o));

  // R3
  mask_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_pend_i | set_rirr_i) & mask_i) == '0);

  // R5
  rirr_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_rirr_i & rirr_i) == '0);

  // R10
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

  // R9
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o && !ext_ack_i |=> ext_req_o);
endmodule

bind irq_msi_redirector irq_msi_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msg_valid_o (msg_valid_o),
  .msg_ready_i (msg_ready_i),
  .msg_addr_o  (msg_addr_o),
  .msg_data_o  (msg_data_o),
  .ext_req_o   (ext_req_o),
  .ext_ack_i   (ext_ack_i),
  .clr_pend_i  (clr_pend),
  .set_rirr_i  (set_rirr),
  .mask_i      (mask_v),
  .rirr_i      (rirr_v)
);

// File: tb/tb_irq_msi_redirector.sv
module tb_irq_msi_redirector;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] line = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic [4:0]  cfg_ridx = '0;
  logic [63:0] cfg_rdata;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vec = '0;
  logic        ext_req;
  logic        ext_ack = 1'b0;
  logic [7:0]  ext_vec = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_msi_redirector #(.NUM_PINS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_line_i(line),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .cfg_ridx_i(cfg_ridx), .cfg_rdata_o(cfg_rdata),
    .eoi_valid_i(eoi_valid), .eoi_vec_i(eoi_vec),
    .ext_req_o(ext_req), .ext_ack_i(ext_ack), .ext_vec_i(ext_vec),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic logic [63:0] mk(input bit mask, input bit lvl, input bit pol, input bit dmode,
                                     input logic [2:0] dm, input logic [7:0] vec, input logic [15:0] dest);
    return {dest, 31'b0, mask, lvl, 1'b0, pol, 1'b0, dmode, dm, vec};
  endfunction

  task automatic wr(input int idx, input logic [63:0] v);
    cfg_idx = 5'(idx); cfg_wdata = v; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [63:0] v);
    cfg_ridx = 5'(idx); #1; v = cfg_rdata;
  endtask

  task automatic expect_msg(input logic [15:0] dest, input bit dmode, input bit lvl,
                            input logic [2:0] dm, input logic [7:0] vec, input string tag);
    logic [31:0] a, d;
    a = 32'hFEE0_0000 | ({16'b0, dest} << 12) | ({31'b0, dmode} << 2);
    d = {16'b0, lvl, 4'b0, dm, vec};
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_vec = v; eoi_valid = 1'b1;
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) tick();
    check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) tick();
    check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R4/R5 unexpected message", {msg_addr, msg_data}, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({msg_addr, msg_data} == e, t, {msg_addr, msg_data}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(0, v);  check(v == 64'h1_0000, "R1 entry0", v, 64'h1_0000);
    rd(23, v); check(v == 64'h1_0000, "R1 entry23", v, 64'h1_0000);
    check(!msg_valid && !ext_req, "R1 outputs idle", {62'b0, msg_valid, ext_req}, 64'd0);

    // R2 read-back, bit 14 ignored
    wr(20, 64'hA5A5_0F0F_3C3C_7FFF | 64'h1_4000);
    rd(20, v);
    check(v == ((64'hA5A5_0F0F_3C3C_7FFF | 64'h1_4000) & ~64'h4000), "R2 readback rirr ro",
          v, (64'hA5A5_0F0F_3C3C_7FFF | 64'h1_4000) & ~64'h4000);

    // R4 R7 R8 edge pin 4
    wr(4, mk(0, 0, 0, 1, 3'd1, 8'h41, 16'hABCD));
    expect_msg(16'hABCD, 1, 0, 3'd1, 8'h41, "R4/R7/R8 edge msg");
    line[4] = 1'b1;
    drain("R4 edge delivered");
    quiet(40, "R4 one msg per edge");
    line[4] = 1'b0; tick(); tick();
    expect_msg(16'hABCD, 1, 0, 3'd1, 8'h41, "R4 second edge");
    line[4] = 1'b1;
    drain("R4 second edge delivered");

    // R3 masked pin keeps pending
    wr(1, mk(1, 0, 0, 0, 3'd0, 8'h21, 16'h0012));
    line[1] = 1'b1;
    quiet(60, "R3 masked no msg");
    expect_msg(16'h0012, 0, 0, 3'd0, 8'h21, "R3 unmask delivers");
    wr(1, mk(0, 0, 0, 0, 3'd0, 8'h21, 16'h0012));
    drain("R3 pending kept");

    // R5 R6 level pin 6
    wr(6, mk(0, 1, 0, 0, 3'd0, 8'h66, 16'h0003));
    expect_msg(16'h0003, 0, 1, 3'd0, 8'h66, "R5/R8 level msg");
    line[6] = 1'b1;
    drain("R5 level delivered");
    quiet(40, "R5 coalesced");
    rd(6, v); check(v[14] == 1'b1, "R5 rirr set", {63'b0, v[14]}, 64'd1);
    eoi(8'h67);
    quiet(30, "R6 mismatched eoi no msg");
    rd(6, v); check(v[14] == 1'b1, "R6 rirr kept", {63'b0, v[14]}, 64'd1);
    expect_msg(16'h0003, 0, 1, 3'd0, 8'h66, "R6 redelivery");
    eoi(8'h66);
    drain("R6 repend after eoi");
    line[6] = 1'b0; tick();
    eoi(8'h66);
    quiet(40, "R6 no msg when line low");
    rd(6, v); check(v[14] == 1'b0, "R6 rirr cleared", {63'b0, v[14]}, 64'd0);

    // R4 polarity: active-low level pin 10
    line[10] = 1'b1; tick();
    wr(10, mk(0, 1, 1, 0, 3'd2, 8'h5A, 16'h0044));
    quiet(40, "R4 inverted idle");
    expect_msg(16'h0044, 0, 1, 3'd2, 8'h5A, "R4 polarity msg");
    line[10] = 1'b0;
    drain("R4 active-low delivered");
    line[10] = 1'b1; tick();
    eoi(8'h5A);
    quiet(30, "R4 deasserted after eoi");

    // R9 external vector
    wr(8, mk(0, 0, 0, 1, 3'b111, 8'h12, 16'h0077));
    expect_msg(16'h0077, 1, 0, 3'b111, 8'h99, "R9 ext vector msg");
    line[8] = 1'b1;
    for (int i = 0; i < 100 && !ext_req; i++) tick();
    check(ext_req == 1'b1, "R9 ext_req raised", {63'b0, ext_req}, 64'd1);
    tick(); tick(); tick();
    check(ext_req && !msg_valid, "R9 ext_req held", {62'b0, ext_req, msg_valid}, 64'd2);
    ext_vec = 8'h99; ext_ack = 1'b1;
    tick();
    ext_ack = 1'b0; ext_vec = 8'h00;
    drain("R9 delivered");
    check(!ext_req, "R9 ext_req dropped", {63'b0, ext_req}, 64'd0);

    // R10 R11 stall and resume order
    wr(12, mk(0, 0, 0, 0, 3'd0, 8'h2C, 16'h000C));
    wr(15, mk(0, 0, 0, 0, 3'd0, 8'h2F, 16'h000F));
    wr(11, mk(0, 0, 0, 0, 3'd0, 8'h2B, 16'h000B));
    msg_ready = 1'b0;
    expect_msg(16'h000C, 0, 0, 3'd0, 8'h2C, "R10 stalled msg pin12");
    expect_msg(16'h000F, 0, 0, 3'd0, 8'h2F, "R11 next upward pin15");
    expect_msg(16'h000B, 0, 0, 3'd0, 8'h2B, "R11 wrapped pin11");
    line[12] = 1'b1;
    for (int i = 0; i < 100 && !msg_valid; i++) tick();
    line[11] = 1'b1; line[15] = 1'b1;
    repeat (10) tick();
    check(msg_valid && msg_addr == (32'hFEE0_0000 | 32'h0000_C000), "R10 held under stall",
          {32'b0, msg_addr}, 64'hFEE0_C000);
    msg_ready = 1'b1;
    drain("R11 order drained");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule